// File: doc/BRIEF.md
# Frame Buffer Line Fill Engine

This block fills a run of consecutive words in a double-buffered frame buffer with a single value. Software programs a fill length and a start word address through a small register port. It then writes the fill value, and that write starts the engine. The engine issues one memory write per clock to the buffer that is not on display. The word address advances only in its low byte, so a fill wraps around inside its 256-word line and never leaves it.

The block also owns the display buffer select bit. A request to flip that bit is applied at once when the display is in vertical blanking or the display mode field is zero. Otherwise the request is held and applied at the next start of vertical blanking. Scan-out and the memory array sit outside the block. The memory array is reached through the write port `mem_*`.

Top module: `fb_fill_engine`

## Requirements
- R1: The fill length register is 8 bits wide. A fill writes length+1 words, one on each clock, and the first write appears on the clock after the write that started the fill.
- R2: A write to register index 2 (fill data) while idle starts a fill with the value just written. `busy` is high from the next clock until the last word has been written.
- R3: The word address of each write is one above that of the previous write in its low 8 bits, wrapping from 0xFF to 0x00. The upper 8 bits never change during a fill.
- R4: After a fill, the start address register (index 1) holds the address that follows the last word written, computed with the same wrap. The data register holds the fill value and the length register (index 0) is unchanged.
- R5: Every write of a fill goes to the bank given by the inverse of `disp_sel` at the moment the fill started. The bank stays constant for the whole fill.
- R6: A write to register index 3 (buffer select, value in bit 0) changes `disp_sel` on the next clock when `vblank` is high or `disp_mode` is zero.
- R7: In all other cases a select write that differs from `disp_sel` sets `swap_pend`, and `disp_sel` does not change. The pending value is applied on the clock that sees `vblank` rise. A select write equal to the current `disp_sel` clears `swap_pend`.
- R8: Register writes of any index received while `busy` is high are ignored.
- R9: After reset all registers read zero, `disp_sel` is 0, `swap_pend` is 0 and `busy` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index: 0 length, 1 start address, 2 fill data, 3 buffer select |
| reg_wdata | input | 16 | Register write data |
| vblank | input | 1 | Vertical blanking active |
| disp_mode | input | 2 | Display mode field; zero means display off |
| len_q | output | 8 | Fill length register |
| addr_q | output | 16 | Start / next word address register |
| data_q | output | 16 | Fill data register |
| disp_sel | output | 1 | Buffer currently displayed |
| swap_pend | output | 1 | Buffer select request waiting for blanking |
| busy | output | 1 | Fill in progress |
| mem_we | output | 1 | Frame buffer write enable |
| mem_bank | output | 1 | Frame buffer targeted by the write |
| mem_addr | output | 16 | Word address of the write |
| mem_wdata | output | 16 | Word written |

## Verification
The assertions check on every cycle the properties that hold between neighbouring cycles. They check that the address steps with a wrap inside the line and that the bank stays constant during a fill. They check that `disp_sel` moves only under blanking or mode zero, that a write while idle starts a fill, and that writes while busy leave the registers unchanged. Only the bench's scenarios can show the full results: the exact count of words for every length from 0 to 255, the final address after a wrap, the deferral of a pending swap to the rising edge of `vblank`, and the cancelling of a pending swap by writing the displayed value back.

// File: rtl/fb_fill_pkg.sv
// Shared definitions for the frame buffer fill engine.
// Assumes a 2-bit register index on the software port.
package fb_fill_pkg;
    typedef enum logic [1:0] {
        REG_LEN  = 2'd0,
        REG_ADDR = 2'd1,
        REG_DATA = 2'd2,
        REG_SEL  = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/fb_fill_regs.sv
// Register file of the fill engine: length, start address and fill data.
// The address register also serves as the running write pointer: each
// step advances its low LINE_W bits only, so after a fill it holds the
// word that follows the last one written. Assumes writes are already
// gated off by the top while a fill runs.
module fb_fill_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_len,
    input  logic              wr_addr,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int HI_W = ADDR_W - LINE_W;

    // Length register: loaded by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (wr_len)
            len_q <= wdata[LEN_W-1:0];
    end

    // Address register: loaded by software, stepped inside the line by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (wr_addr)
            addr_q <= wdata[ADDR_W-1:0];
        else if (step)
            addr_q <= {addr_q[ADDR_W-1 -: HI_W], addr_q[LINE_W-1:0] + LINE_W'(1)};
    end

    // Data register: the write that starts a fill also stores its value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (wr_data)
            data_q <= wdata;
    end
endmodule

// File: rtl/fb_fill_seq.sv
// Fill sequencer: counts len+1 write cycles after a start pulse and
// latches the target bank (the buffer not displayed) at start time.
// Assumes start is only pulsed while idle.
module fb_fill_seq #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             disp_sel,
    output logic             busy,
    output logic             bank,
    output logic             step
);
    logic [LEN_W-1:0] remain_q;

    // Busy flag and remaining-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            remain_q <= len;
        end else if (busy) begin
            if (remain_q == '0)
                busy <= 1'b0;
            else
                remain_q <= remain_q - LEN_W'(1);
        end
    end

    // Target bank: inverse of the displayed buffer, frozen for the whole fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= 1'b1;
        else if (start)
            bank <= ~disp_sel;
    end

    assign step = busy;
endmodule

// File: rtl/fb_swap_ctrl.sv
// Display buffer select control. A request is applied at once during
// vertical blanking or with the display mode field at zero. Otherwise it is
// held and applied on the clock that sees vblank rise.
// Assumes vblank is synchronous to clk.
module fb_swap_ctrl #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              sel_val,
    input  logic              vblank,
    input  logic [MODE_W-1:0] disp_mode,
    output logic              disp_sel,
    output logic              swap_pend
);
    logic vblank_q;
    logic req_q;
    logic may_swap;
    logic vb_rise;

    assign may_swap = vblank || (disp_mode == '0);
    assign vb_rise  = vblank && !vblank_q;

    // Blanking edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vblank_q <= 1'b0;
        else
            vblank_q <= vblank;
    end

    // Select bit, pending flag and pending value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_sel  <= 1'b0;
            swap_pend <= 1'b0;
            req_q     <= 1'b0;
        end else if (wr_sel) begin
            if (may_swap) begin
                disp_sel  <= sel_val;
                swap_pend <= 1'b0;
            end else begin
                swap_pend <= (sel_val != disp_sel);
                req_q     <= sel_val;
            end
        end else if (swap_pend && vb_rise) begin
            disp_sel  <= req_q;
            swap_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/fb_fill_engine.sv
// Top of the frame buffer fill engine. It decodes the register port and
// gates every write off while a fill runs. It joins the registers, the
// sequencer and the swap control, and drives the memory write port.
// Assumes one memory write per clock is always accepted.
module fb_fill_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int LINE_W = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              vblank,
    input  logic [MODE_W-1:0] disp_mode,
    output logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              disp_sel,
    output logic              swap_pend,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import fb_fill_pkg::*;

    logic     wr_ok;
    logic     step;
    reg_idx_e idx;

    // Register decode: accepted only while idle.
    assign idx   = reg_idx_e'(reg_idx);
    assign wr_ok = reg_we && !busy;

    fb_fill_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LINE_W(LINE_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_len (wr_ok && idx == REG_LEN),
        .wr_addr(wr_ok && idx == REG_ADDR),
        .wr_data(wr_ok && idx == REG_DATA),
        .wdata  (reg_wdata),
        .step   (step),
        .len_q  (len_q),
        .addr_q (addr_q),
        .data_q (data_q)
    );

    fb_fill_seq #(.LEN_W(LEN_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_ok && idx == REG_DATA),
        .len     (len_q),
        .disp_sel(disp_sel),
        .busy    (busy),
        .bank    (mem_bank),
        .step    (step)
    );

    fb_swap_ctrl #(.MODE_W(MODE_W)) u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_ok && idx == REG_SEL),
        .sel_val  (reg_wdata[0]),
        .vblank   (vblank),
        .disp_mode(disp_mode),
        .disp_sel (disp_sel),
        .swap_pend(swap_pend)
    );

    // Memory write port: the running address and the stored value.
    assign mem_we    = step;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
endmodule

// File: rtl/fb_fill_checker.sv
// Cycle-by-cycle properties of the fill engine, bound to the top.
module fb_fill_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int LINE_W = 8,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_idx,
    input logic              vblank,
    input logic [MODE_W-1:0] disp_mode,
    input logic [LEN_W-1:0]  len_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [DATA_W-1:0] data_q,
    input logic              disp_sel,
    input logic              busy,
    input logic              mem_we,
    input logic              mem_bank,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[ADDR_W-1:LINE_W] == $past(mem_addr[ADDR_W-1:LINE_W])) &&
            (mem_addr[LINE_W-1:0] == $past(mem_addr[LINE_W-1:0]) + LINE_W'(1)));

    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> $stable(mem_bank));

    assert_swap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_sel) |-> ($past(vblank) || $past(disp_mode) == '0));

    assert_start_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 2'd2 && !busy) |=> busy);

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && busy) |=> ($stable(len_q) && $stable(data_q) && $stable(disp_sel)));
endmodule

bind fb_fill_engine fb_fill_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LINE_W(LINE_W), .MODE_W(MODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .vblank(vblank),
    .disp_mode(disp_mode), .len_q(len_q), .addr_q(addr_q), .data_q(data_q),
    .disp_sel(disp_sel), .busy(busy), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_addr(mem_addr)
);

// File: tb/fb_fill_engine_tb.sv
module fb_fill_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic        vblank = 1'b0;
    logic [1:0]  disp_mode = 2'd1;
    logic [7:0]  len_q;
    logic [15:0] addr_q, data_q, mem_addr, mem_wdata;
    logic        disp_sel, swap_pend, busy, mem_we, mem_bank;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic exp_fs = 1'b0;

    fb_fill_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .vblank(vblank), .disp_mode(disp_mode),
        .len_q(len_q), .addr_q(addr_q), .data_q(data_q), .disp_sel(disp_sel),
        .swap_pend(swap_pend), .busy(busy), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [15:0] val);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        tick();
        reg_we = 1'b0;
    endtask

    // Program a fill and follow every write; optionally intrude with writes while busy.
    task automatic run_fill(input logic [15:0] start, input logic [7:0] len,
                            input logic [15:0] val, input bit intrude);
        logic [15:0] ea;
        int bad_a = 0, bad_d = 0, bad_b = 0, bad_w = 0;
        logic [15:0] last_a = 16'h0;
        wr(2'd0, {8'h00, len});
        wr(2'd1, start);
        wr(2'd2, val);
        for (int i = 0; i <= int'(len); i++) begin
            ea = {start[15:8], 8'(start[7:0] + i)};
            if (!mem_we || !busy) bad_w++;
            if (mem_addr != ea) begin bad_a++; last_a = mem_addr; end
            if (mem_wdata != val) bad_d++;
            if (mem_bank != ~exp_fs) bad_b++;
            if (intrude && i >= 2 && i <= 5) begin
                reg_we = 1'b1; reg_idx = 2'(i - 2); reg_wdata = 16'hBEEF;
                vblank = 1'b1;
                @(posedge clk);
                reg_we = 1'b0;
                vblank = 1'b0;
                @(negedge clk);
            end else begin
                tick();
            end
        end
        check(bad_w == 0, "R1 write count/busy", bad_w, 0);
        check(!mem_we && !busy, "R1 fill length ends", {mem_we, busy}, 0);
        check(bad_a == 0, "R3 address sequence", last_a, 0);
        check(bad_d == 0, "R2 fill value", bad_d, 0);
        check(bad_b == 0, "R5 target bank", bad_b, 0);
        ea = {start[15:8], 8'(start[7:0] + int'(len) + 1)};
        check(addr_q == ea, "R4 next address", addr_q, ea);
        check(data_q == val, "R4 data register", data_q, val);
        check(len_q == len, "R4/R8 length register", len_q, len);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R9 reset state
        check(len_q == 0 && addr_q == 0 && data_q == 0, "R9 registers", {len_q, addr_q}, 0);
        check(!disp_sel && !swap_pend, "R9 select", {disp_sel, swap_pend}, 0);
        check(!busy && !mem_we, "R9 idle", {busy, mem_we}, 0);

        // R6 immediate swap under blanking
        vblank = 1'b1;
        wr(2'd3, 16'h0001); exp_fs = 1'b1;
        check(disp_sel == 1'b1 && !swap_pend, "R6 swap in vblank", disp_sel, 1);
        vblank = 1'b0;
        // R6 immediate swap with mode zero
        disp_mode = 2'd0;
        wr(2'd3, 16'h0000); exp_fs = 1'b0;
        check(disp_sel == 1'b0 && !swap_pend, "R6 swap at mode zero", disp_sel, 0);
        disp_mode = 2'd1;
        // R7 deferred swap
        wr(2'd3, 16'h0001);
        check(disp_sel == 1'b0 && swap_pend, "R7 swap held", {disp_sel, swap_pend}, 2'b01);
        tick();
        check(disp_sel == 1'b0, "R7 still held", disp_sel, 0);
        vblank = 1'b1;
        tick(); exp_fs = 1'b1;
        check(disp_sel == 1'b1 && !swap_pend, "R7 applied at vblank rise",
              {disp_sel, swap_pend}, 2'b10);
        vblank = 1'b0;
        tick();
        // R7 cancel by writing the displayed value back
        wr(2'd3, 16'h0000);
        check(swap_pend, "R7 pending set", swap_pend, 1);
        wr(2'd3, 16'h0001);
        check(!swap_pend, "R7 pending cleared", swap_pend, 0);
        vblank = 1'b1; tick(); vblank = 1'b0; tick();
        check(disp_sel == 1'b1, "R7 no swap after cancel", disp_sel, 1);

        // Corner fills: single word, wrap, full line
        run_fill(16'h1234, 8'd0, 16'hA5A5, 1'b0);
        run_fill(16'h12F0, 8'h1F, 16'h0F0F, 1'b0);
        run_fill(16'h4480, 8'hFF, 16'hFFFF, 1'b0);

        // R8 writes while busy are ignored (length, address, data, select)
        run_fill(16'h0300, 8'd20, 16'h1111, 1'b1);
        check(disp_sel == exp_fs, "R8 select ignored", disp_sel, exp_fs);

        // Sweep every length, both banks
        for (int n = 0; n < 256; n++) begin
            if (n % 64 == 0) begin
                vblank = 1'b1;
                wr(2'd3, {15'h0, ~exp_fs}); exp_fs = ~exp_fs;
                vblank = 1'b0;
            end
            run_fill({8'(n ^ 8'hA5), 8'(n * 37)}, 8'(n), 16'(n * 16'h0101) ^ 16'h5A5A, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule